// File: doc/BRIEF.md
# Ethernet Transmit Frame Serializer

This block converts a stream of frame bytes into a serial NRZ bit stream, one bit per clock. After a start request it emits a fixed preamble and a two-bit start delimiter. It then pulls the frame contents one byte at a time and shifts each byte out. A 32-bit frame check sequence is computed over the contents and sent after the final byte. The line is framed by a transmit-enable, and a one-cycle pulse marks how the frame ended.

A collision input flagged while the frame is on the line cuts the frame short. The block then sends a fixed run of ones so that other stations see the collision, and raises an abort pulse. If the byte source has nothing ready at the moment a byte is due, the block treats this as an underrun and ends the frame the same way. Line coding, retry timing and memory transfers belong to the surrounding logic.

Top module: `frame_tx_serializer`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, `tx_en_o`, `txd_o`, `byte_ready_o`, `done_o`, `abort_o` and `underrun_o` are all 0.
- R2: When `start_i` is high at a clock edge while idle, `tx_en_o` rises after that edge. The first 62 bit times carry 1,0,1,0,… starting with 1, and the next two bit times carry 1,1.
- R3: Frame bytes are sent least significant bit first, eight bit times per byte. A byte is taken only at an edge where `byte_ready_o` and `byte_valid_i` are both high. `byte_ready_o` is high only in the last bit time of the delimiter or of a byte not flagged with `byte_last_i`, so `byte_valid_i` has no effect at other times.
- R4: After the last bit of the byte taken with `byte_last_i`=1, 32 check bits follow. They are the standard Ethernet FCS: CRC-32 with generator 0x04C11DB7, register preset to all ones, computed over the content bits in line order only. The register complement is sent most significant bit first, which equals the reflected CRC-32 result sent LSB first.
- R5: `tx_en_o` stays high from the first preamble bit through the last check bit and then drops. `done_o` is high for exactly the first cycle after, and `txd_o` is 0 whenever `tx_en_o` is 0.
- R6: `coll_i` high at an edge while preamble, delimiter, content or check bits are on the line makes the next bit time the first of 32 ones. No byte is taken at that edge. `tx_en_o` drops after the 32nd one, `abort_o` is high for that single following cycle, and `done_o` stays low.
- R7: If `byte_valid_i` is low at an edge where a byte is due, `underrun_o` pulses in the first of 32 ones. The frame then ends as in R6 with `abort_o`.
- R8: `start_i` has no effect while a frame or jam is on the line, including during its last bit. `coll_i` has no effect while idle or while the ones run is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a frame, honoured only while idle |
| byte_data_i | input | 8 | Frame content byte |
| byte_valid_i | input | 1 | Content byte available |
| byte_last_i | input | 1 | Current byte is the final content byte |
| byte_ready_o | output | 1 | Block takes the byte at the next edge if valid |
| coll_i | input | 1 | Collision flag from the line |
| txd_o | output | 1 | Serial NRZ data |
| tx_en_o | output | 1 | High while a bit is on the line |
| done_o | output | 1 | One-cycle pulse after a frame ends normally |
| abort_o | output | 1 | One-cycle pulse after a collision or underrun jam ends |
| underrun_o | output | 1 | One-cycle pulse in the first jam bit after a missing byte |

## Verification
The assertions check several local rules on every cycle. A frame opens with a 1 bit right after an accepted start. Every line bit after an observed collision is a one. The ready signal never appears off the line or during a collision. Each end pulse sits on the cycle where transmit-enable falls, and an underrun pulse always lands on a jam bit. The full bit order can only be shown by the bench comparing whole frames against a stream it builds independently: preamble, delimiter, LSB-first bytes, and the check sequence from a reflected CRC-32. The same applies to the exact jam position for collisions in each phase and to the ignoring of the valid flag between byte boundaries.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_DATA = 3'd2,
        ST_FCS  = 3'd3,
        ST_JAM  = 3'd4
    } ftx_state_e;

    function automatic int ftx_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ftx_crc.sv
module ftx_crc
    import ftx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic upd_i,
    input  logic bit_i,
    input  logic shift_i,
    output logic msb_o
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_st_t;

    crc_st_t crc_d, crc_q;

    // Serial update, MSB-aligned register; shift mode drains the register for output.
    always_comb begin
        crc_d = crc_q;
        if (init_i) begin
            crc_d.crc = '1;
        end else if (upd_i) begin
            crc_d.crc = {crc_q.crc[CRC_W-2:0], 1'b0}
                      ^ ((crc_q.crc[CRC_W-1] ^ bit_i) ? CRC_POLY : '0);
        end else if (shift_i) begin
            crc_d.crc = {crc_q.crc[CRC_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '{crc: '1};
        end else begin
            crc_q <= crc_d;
        end
    end

    assign msb_o = crc_q.crc[CRC_W-1];

endmodule

// File: rtl/ftx_preamble.sv
module ftx_preamble #(
    parameter int PRE_BITS = 62,
    parameter int SFD_BITS = 2,
    parameter int CNT_W    = 7
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             bit_o,
    output logic             final_o
);

    localparam logic [CNT_W-1:0] PRE_LIM = CNT_W'(PRE_BITS);
    localparam logic [CNT_W-1:0] HDR_LIM = CNT_W'(PRE_BITS + SFD_BITS);

    // cnt_i is the index of the next header bit to be placed on the line.
    always_comb begin
        if (cnt_i < PRE_LIM) begin
            bit_o = ~cnt_i[0];
        end else begin
            bit_o = 1'b1;
        end
    end

    assign final_o = (cnt_i == HDR_LIM);

endmodule

// File: rtl/ftx_ctrl.sv
module ftx_ctrl
    import ftx_pkg::*;
#(
    parameter int PRE_BITS = 62,
    parameter int SFD_BITS = 2,
    parameter int JAM_BITS = 32,
    parameter int BYTE_W   = 8,
    parameter int CNT_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              byte_valid_i,
    input  logic              byte_last_i,
    output logic              byte_ready_o,
    input  logic              coll_i,
    input  logic              pre_bit_i,
    input  logic              pre_final_i,
    input  logic              crc_msb_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              crc_init_o,
    output logic              crc_upd_o,
    output logic              crc_bit_o,
    output logic              crc_shift_o,
    output logic              txd_o,
    output logic              tx_en_o,
    output logic              done_o,
    output logic              abort_o,
    output logic              underrun_o
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(CRC_W);
    localparam logic [CNT_W-1:0] JAM_END  = CNT_W'(JAM_BITS);

    typedef struct packed {
        ftx_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              last;
        logic              txd;
        logic              txen;
        logic              done;
        logic              abort;
        logic              urun;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, cnt: '0, sh: '0, last: 1'b0, txd: 1'b0,
        txen: 1'b0, done: 1'b0, abort: 1'b0, urun: 1'b0
    };

    ctl_t ctl_d, ctl_q;
    logic need_byte;
    logic on_line;
    logic fetch;

    assign need_byte = ((ctl_q.st == ST_PRE) && pre_final_i)
                    || ((ctl_q.st == ST_DATA) && (ctl_q.cnt == BYTE_END) && !ctl_q.last);
    assign on_line   = (ctl_q.st == ST_PRE) || (ctl_q.st == ST_DATA) || (ctl_q.st == ST_FCS);
    assign byte_ready_o = need_byte && !coll_i;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.abort = 1'b0;
        ctl_d.urun  = 1'b0;
        crc_init_o  = 1'b0;
        crc_upd_o   = 1'b0;
        crc_bit_o   = 1'b0;
        crc_shift_o = 1'b0;
        fetch       = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_PRE;
                    ctl_d.txen = 1'b1;
                    ctl_d.txd  = pre_bit_i;
                    ctl_d.cnt  = CNT_ONE;
                    crc_init_o = 1'b1;
                end
            end
            ST_PRE: begin
                if (pre_final_i) begin
                    fetch = 1'b1;
                end else begin
                    ctl_d.txd = pre_bit_i;
                    ctl_d.cnt = ctl_q.cnt + CNT_ONE;
                end
            end
            ST_DATA: begin
                if (ctl_q.cnt == BYTE_END) begin
                    if (ctl_q.last) begin
                        ctl_d.st    = ST_FCS;
                        ctl_d.txd   = ~crc_msb_i;
                        ctl_d.cnt   = CNT_ONE;
                        crc_shift_o = 1'b1;
                    end else begin
                        fetch = 1'b1;
                    end
                end else begin
                    ctl_d.txd = ctl_q.sh[0];
                    ctl_d.sh  = ctl_q.sh >> 1;
                    ctl_d.cnt = ctl_q.cnt + CNT_ONE;
                    crc_upd_o = 1'b1;
                    crc_bit_o = ctl_q.sh[0];
                end
            end
            ST_FCS: begin
                if (ctl_q.cnt == CRC_END) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.txen = 1'b0;
                    ctl_d.txd  = 1'b0;
                    ctl_d.cnt  = '0;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.txd   = ~crc_msb_i;
                    ctl_d.cnt   = ctl_q.cnt + CNT_ONE;
                    crc_shift_o = 1'b1;
                end
            end
            ST_JAM: begin
                if (ctl_q.cnt == JAM_END) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.txen  = 1'b0;
                    ctl_d.txd   = 1'b0;
                    ctl_d.cnt   = '0;
                    ctl_d.abort = 1'b1;
                end else begin
                    ctl_d.txd = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + CNT_ONE;
                end
            end
            default: begin
                ctl_d = CTL_RST;
            end
        endcase

        // Byte boundary: take the next byte or fall into the jam on a missing byte.
        if (fetch) begin
            if (byte_valid_i) begin
                ctl_d.st   = ST_DATA;
                ctl_d.txd  = byte_data_i[0];
                ctl_d.sh   = byte_data_i >> 1;
                ctl_d.last = byte_last_i;
                ctl_d.cnt  = CNT_ONE;
                crc_upd_o  = 1'b1;
                crc_bit_o  = byte_data_i[0];
            end else begin
                ctl_d.st   = ST_JAM;
                ctl_d.txd  = 1'b1;
                ctl_d.cnt  = CNT_ONE;
                ctl_d.urun = 1'b1;
            end
        end

        // A collision overrides every other decision while the frame is on the line.
        if (on_line && coll_i) begin
            ctl_d.st    = ST_JAM;
            ctl_d.txd   = 1'b1;
            ctl_d.txen  = 1'b1;
            ctl_d.cnt   = CNT_ONE;
            ctl_d.done  = 1'b0;
            ctl_d.urun  = 1'b0;
            crc_upd_o   = 1'b0;
            crc_shift_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cnt_o      = ctl_q.cnt;
    assign txd_o      = ctl_q.txd;
    assign tx_en_o    = ctl_q.txen;
    assign done_o     = ctl_q.done;
    assign abort_o    = ctl_q.abort;
    assign underrun_o = ctl_q.urun;

endmodule

// File: rtl/frame_tx_serializer.sv
module frame_tx_serializer
    import ftx_pkg::*;
#(
    parameter int PRE_BITS = 62,
    parameter int SFD_BITS = 2,
    parameter int JAM_BITS = 32,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              byte_valid_i,
    input  logic              byte_last_i,
    output logic              byte_ready_o,
    input  logic              coll_i,
    output logic              txd_o,
    output logic              tx_en_o,
    output logic              done_o,
    output logic              abort_o,
    output logic              underrun_o
);

    localparam int CNT_MAX = ftx_max(ftx_max(PRE_BITS + SFD_BITS, JAM_BITS),
                                     ftx_max(CRC_W, BYTE_W));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic pre_bit, pre_final;
    logic crc_init, crc_upd, crc_bit, crc_shift, crc_msb;

    ftx_preamble #(
        .PRE_BITS (PRE_BITS),
        .SFD_BITS (SFD_BITS),
        .CNT_W    (CNT_W)
    ) u_pre (
        .cnt_i   (cnt),
        .bit_o   (pre_bit),
        .final_o (pre_final)
    );

    ftx_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (crc_init),
        .upd_i   (crc_upd),
        .bit_i   (crc_bit),
        .shift_i (crc_shift),
        .msb_o   (crc_msb)
    );

    ftx_ctrl #(
        .PRE_BITS (PRE_BITS),
        .SFD_BITS (SFD_BITS),
        .JAM_BITS (JAM_BITS),
        .BYTE_W   (BYTE_W),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_data_i  (byte_data_i),
        .byte_valid_i (byte_valid_i),
        .byte_last_i  (byte_last_i),
        .byte_ready_o (byte_ready_o),
        .coll_i       (coll_i),
        .pre_bit_i    (pre_bit),
        .pre_final_i  (pre_final),
        .crc_msb_i    (crc_msb),
        .cnt_o        (cnt),
        .crc_init_o   (crc_init),
        .crc_upd_o    (crc_upd),
        .crc_bit_o    (crc_bit),
        .crc_shift_o  (crc_shift),
        .txd_o        (txd_o),
        .tx_en_o      (tx_en_o),
        .done_o       (done_o),
        .abort_o      (abort_o),
        .underrun_o   (underrun_o)
    );

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic byte_valid_i,
    input logic coll_i,
    input logic byte_ready_o,
    input logic txd_o,
    input logic tx_en_o,
    input logic done_o,
    input logic abort_o,
    input logic underrun_o
);

    // R2
    preamble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> (txd_o && $past(start_i)));

    // R3
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (tx_en_o && !coll_i));

    // R5
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!tx_en_o && $past(tx_en_o) && !abort_o));

    // R5
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_o |-> !txd_o);

    // R6
    collision_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o && $past(tx_en_o) && $past(coll_i)) |-> txd_o);

    // R6
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!tx_en_o && $past(tx_en_o) && $past(txd_o)));

    // R7
    underrun_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> (tx_en_o && txd_o && !$past(byte_valid_i)));

endmodule

bind frame_tx_serializer ftx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .coll_i       (coll_i),
    .byte_ready_o (byte_ready_o),
    .txd_o        (txd_o),
    .tx_en_o      (tx_en_o),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .underrun_o   (underrun_o)
);

// File: tb/frame_tx_serializer_tb.sv
module frame_tx_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] byte_data_i = '0;
    logic       byte_valid_i = 1'b0;
    logic       byte_last_i = 1'b0;
    logic       coll_i = 1'b0;
    logic       byte_ready_o, txd_o, tx_en_o, done_o, abort_o, underrun_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] mem [0:63];
    logic       exp_bits [0:1023];

    always #5ns clk = ~clk;

    frame_tx_serializer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_data_i  (byte_data_i),
        .byte_valid_i (byte_valid_i),
        .byte_last_i  (byte_last_i),
        .byte_ready_o (byte_ready_o),
        .coll_i       (coll_i),
        .txd_o        (txd_o),
        .tx_en_o      (tx_en_o),
        .done_o       (done_o),
        .abort_o      (abort_o),
        .underrun_o   (underrun_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Reflected CRC-32 over mem[0..len-1]; returned value goes on the wire LSB first.
    function automatic logic [31:0] ref_fcs(input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'h0, mem[i]};
            for (int b = 0; b < 8; b++) begin
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    // len: content bytes; coll_at: bit time with collision (-1 none);
    // ur_at: byte index missing (-1 none); poke: bit time with extra start; gap: valid only at boundaries
    task automatic run_frame(input int len, input int seed, input int coll_at,
                             input int ur_at, input int poke, input bit gap);
        int nexp, full, jam_from, total, idx, bad, first_bad, ubad, pbad;
        bit ab, took;
        logic [31:0] fcs;
        string reg_s;
        for (int i = 0; i < len; i++) begin
            mem[i] = 8'((seed * 29 + i * 71 + i * i) ^ (seed << 3));
        end
        fcs = ref_fcs(len);
        nexp = 0;
        for (int i = 0; i < 62; i++) begin exp_bits[nexp] = (i % 2 == 0); nexp++; end
        for (int i = 0; i < 2; i++) begin exp_bits[nexp] = 1'b1; nexp++; end
        for (int i = 0; i < len; i++) begin
            for (int b = 0; b < 8; b++) begin exp_bits[nexp] = mem[i][b]; nexp++; end
        end
        for (int i = 0; i < 32; i++) begin exp_bits[nexp] = fcs[i]; nexp++; end
        full = nexp;
        jam_from = -1;
        if (ur_at >= 0) jam_from = 64 + 8 * ur_at;
        if (coll_at >= 0) jam_from = coll_at + 1;
        ab = (jam_from >= 0);
        total = full;
        if (ab) begin
            for (int i = 0; i < 32; i++) exp_bits[jam_from + i] = 1'b1;
            total = jam_from + 32;
        end

        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        idx = 0; took = 1'b0; bad = 0; first_bad = 0; ubad = 0; pbad = 0;
        for (int c = 0; c < total; c++) begin
            if (took) begin idx++; took = 1'b0; end
            byte_data_i  = mem[(idx < len) ? idx : 0];
            byte_last_i  = (idx == len - 1);
            byte_valid_i = gap ? (c >= 63 && ((c - 63) % 8) == 0) : (idx != ur_at);
            coll_i       = (c == coll_at);
            start_i      = (c == poke);
            #1ns;
            if (tx_en_o !== 1'b1 || txd_o !== exp_bits[c]) begin
                if (bad == 0) first_bad = c;
                bad++;
            end
            if (underrun_o !== (ur_at >= 0 && c == jam_from)) ubad++;
            if (done_o !== 1'b0 || abort_o !== 1'b0) pbad++;
            if (byte_ready_o && byte_valid_i) took = 1'b1;
            @(negedge clk);
        end
        coll_i = 1'b0;
        start_i = 1'b0;
        byte_valid_i = 1'b0;
        if (ab && first_bad >= jam_from) reg_s = (ur_at >= 0) ? "R7" : "R6";
        else if (first_bad < 64) reg_s = "R2";
        else if (first_bad < 64 + 8 * len) reg_s = "R3";
        else reg_s = "R4";
        check(bad == 0, reg_s, $sformatf("line bit %0d of frame len %0d (mismatches)", first_bad, len),
              bad, 0);
        check(ubad == 0, "R7", "underrun pulse placement (mismatching cycles)", ubad, 0);
        check(pbad == 0, "R5", "end pulse during frame (cycles)", pbad, 0);
        #1ns;
        check(tx_en_o === 1'b0 && txd_o === 1'b0, ab ? "R6" : "R5", "line idle after frame",
              {tx_en_o, txd_o}, 0);
        check(done_o === !ab && abort_o === ab, ab ? "R6" : "R5", "end pulse {done,abort}",
              {done_o, abort_o}, {!ab, ab});
        @(negedge clk);
        #1ns;
        check(done_o === 1'b0 && abort_o === 1'b0 && tx_en_o === 1'b0, "R8",
              "single end pulse and no restart {done,abort,tx_en}",
              {done_o, abort_o, tx_en_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1ns;
        // R1 during reset
        check({tx_en_o, txd_o, byte_ready_o, done_o, abort_o, underrun_o} === 6'b0, "R1",
              "outputs in reset", {tx_en_o, txd_o, byte_ready_o, done_o, abort_o, underrun_o}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1ns;
        // R1 after reset, no start
        check({tx_en_o, txd_o, byte_ready_o, done_o, abort_o, underrun_o} === 6'b0, "R1",
              "outputs idle after reset", {tx_en_o, txd_o, byte_ready_o, done_o, abort_o, underrun_o}, 0);

        // R4 bench reference self-test on the standard check string
        for (int i = 0; i < 9; i++) mem[i] = 8'h31 + 8'(i);
        check(ref_fcs(9) == 32'hCBF4_3926, "R4", "reference CRC-32 of check string",
              ref_fcs(9), 32'hCBF4_3926);

        // R8 collision while idle is ignored
        @(negedge clk);
        coll_i = 1'b1;
        repeat (5) @(negedge clk);
        #1ns;
        check(tx_en_o === 1'b0 && abort_o === 1'b0 && txd_o === 1'b0, "R8",
              "collision while idle {tx_en,abort,txd}", {tx_en_o, abort_o, txd_o}, 0);
        coll_i = 1'b0;

        // R2 R3 R4 R5: sweep of short frames
        for (int l = 1; l <= 8; l++) run_frame(l, l, -1, -1, -1, 1'b0);
        run_frame(46, 9, -1, -1, -1, 1'b0);
        run_frame(64, 10, -1, -1, -1, 1'b0);
        // R3 valid only at byte boundaries
        run_frame(12, 11, -1, -1, -1, 1'b1);
        // R8 start during frame and during last check bit
        run_frame(4, 12, -1, -1, 100, 1'b0);
        run_frame(3, 13, -1, -1, 64 + 24 + 31, 1'b0);
        // R6 collisions in each phase
        run_frame(6, 14, 10, -1, -1, 1'b0);
        run_frame(6, 15, 63, -1, -1, 1'b0);
        run_frame(6, 16, 64 + 16 + 3, -1, -1, 1'b0);
        run_frame(6, 17, 64 + 48 + 5, -1, -1, 1'b0);
        run_frame(6, 18, 64 + 48 + 31, -1, -1, 1'b0);
        // R7 underrun at first byte and mid-frame
        run_frame(5, 19, -1, 0, -1, 1'b0);
        run_frame(5, 20, -1, 3, -1, 1'b0);
        // R8 start during jam is ignored
        run_frame(5, 21, 70, -1, 80, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected earlier completion", 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule